// File: doc/BRIEF.md
# Shifted-Operand Sixteen-Function ALU

This block is the combinational execute stage of a 32-bit integer datapath. It takes a first operand, a second operand that is either a register value passed through a barrel shifter or a ready-made immediate, a 4-bit function code, a flag-update request and the current condition flags. In the same cycle it returns a 32-bit result, a destination write-enable and the next negative, zero, carry and overflow flags.

Sixteen function codes cover bitwise logic, plus and minus in both operand orders with or without the incoming carry, moves, and four test-only codes. The test-only codes leave the destination alone and always refresh the flags. For bitwise and move codes, the carry flag comes from the last bit the shifter pushed out. The overflow flag is not changed by these codes.

Top module: `shift_alu`

## Requirements
- R1: Logical codes: 0000 gives Rn AND Op2, 0001 gives Rn XOR Op2, 1100 gives Rn OR Op2, 1101 gives Op2, 1110 gives Rn AND NOT Op2, 1111 gives NOT Op2. Each of these asserts `rd_we`.
- R2: Arithmetic codes without carry: 0100 gives Rn + Op2, 0010 gives Rn - Op2, 0011 gives Op2 - Rn, all modulo 2^32. Each asserts `rd_we`.
- R3: Carry-using codes take C from `flags_in[1]`: 0101 gives Rn + Op2 + C, 0110 gives Rn - Op2 + C - 1, 0111 gives Op2 - Rn + C - 1.
- R4: Test-only codes hold `rd_we` low and update the flags whatever `set_flags` is. The flags come from AND (1000), XOR (1001), Rn - Op2 (1010) and Rn + Op2 (1011).
- R5: With `use_imm` low, Op2 is `rm` shifted by a nonzero `shift_amt`. `shift_kind` 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right.
- R6: With `shift_amt` zero, Op2 equals `rm`. With `use_imm` high, Op2 equals `imm`. In both cases the shifter carry equals the incoming C.
- R7: When the flags update, N (`flags_out[3]`) is result bit 31 and Z (`flags_out[2]`) is 1 exactly when the result is zero.
- R8: For arithmetic and arithmetic-test codes, C (`flags_out[1]`) is the carry out of bit 31. For subtraction this means no borrow. V (`flags_out[0]`) is 1 when the true signed result does not fit in 32 bits.
- R9: For logical, move and logical-test codes, C becomes the shifter carry and V keeps `flags_in[0]`.
- R10: With `set_flags` low and a non-test code, `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rn | input | 32 | First operand |
| rm | input | 32 | Register value fed to the shifter |
| imm | input | 32 | Already-expanded immediate second operand |
| use_imm | input | 1 | Select `imm` instead of the shifted `rm` |
| shift_kind | input | 2 | Shift type: 00 LL, 01 LR, 10 AR, 11 RR |
| shift_amt | input | 5 | Shift distance, 0 to 31 |
| opcode | input | 4 | Function code |
| set_flags | input | 1 | Request a flag update |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| rd_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
Four properties are checked on every evaluation:
- a rotate keeps the number of one bits;
- a nonzero logical right shift clears the top bit;
- a zero-distance shift is an identity that passes the carry through;
- the adder's carry agrees with whether the sum wrapped below its first operand.

Assertions also hold that test codes never write, that logical codes leave V alone, and that the flags are untouched when no update is asked for.

Exact values need the bench's reference model, run over seeded random and directed vectors. These values include the borrow sense of the reverse and carry subtractions, signed overflow at the 0x7FFFFFFF/0x80000000 edge, and the shifted-out bit for each shift kind.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'h0,
        OP_XOR    = 4'h1,
        OP_SUB    = 4'h2,
        OP_RSUB   = 4'h3,
        OP_ADD    = 4'h4,
        OP_ADDC   = 4'h5,
        OP_SUBC   = 4'h6,
        OP_RSUBC  = 4'h7,
        OP_TSTAND = 4'h8,
        OP_TSTXOR = 4'h9,
        OP_CMPSUB = 4'hA,
        OP_CMPADD = 4'hB,
        OP_OR     = 4'hC,
        OP_PASS   = 4'hD,
        OP_ANDN   = 4'hE,
        OP_NOT    = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_LR = 2'd1,
        SH_AR = 2'd2,
        SH_RR = 2'd3
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        CI_ZERO = 2'd0,
        CI_ONE  = 2'd1,
        CI_FLAG = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     swap;   // put Op2 on the adder's first input
        logic     inv;    // invert the adder's second input
        cin_sel_e cin;
    } arith_ctl_t;

    function automatic logic is_compare(alu_op_e op);
        return op inside {OP_TSTAND, OP_TSTXOR, OP_CMPSUB, OP_CMPADD};
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return op inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
                          OP_CMPSUB, OP_CMPADD};
    endfunction

    function automatic arith_ctl_t arith_ctl(alu_op_e op);
        arith_ctl_t c;
        c = '{swap: 1'b0, inv: 1'b0, cin: CI_ZERO};
        unique case (op)
            OP_SUB, OP_CMPSUB: c = '{swap: 1'b0, inv: 1'b1, cin: CI_ONE};
            OP_RSUB:           c = '{swap: 1'b1, inv: 1'b1, cin: CI_ONE};
            OP_ADDC:           c = '{swap: 1'b0, inv: 1'b0, cin: CI_FLAG};
            OP_SUBC:           c = '{swap: 1'b0, inv: 1'b1, cin: CI_FLAG};
            OP_RSUBC:          c = '{swap: 1'b1, inv: 1'b1, cin: CI_FLAG};
            default:           c = '{swap: 1'b0, inv: 1'b0, cin: CI_ZERO};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  shift_e        kind,
    input  logic [SW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          cout
);
    logic [W:0]   lsl_x, lsr_x, asr_x;
    logic [W-1:0] ror_r;

    always_comb begin
        lsl_x = {1'b0, val} << amt;
        lsr_x = {val, 1'b0} >> amt;
        asr_x = $unsigned($signed({val, 1'b0}) >>> amt);
        ror_r = (val >> amt) | (val << (W - int'(amt)));
        if (amt == '0) begin
            res  = val;
            cout = cin;
        end else begin
            unique case (kind)
                SH_LL: begin res = lsl_x[W-1:0]; cout = lsl_x[W]; end
                SH_LR: begin res = lsr_x[W:1];   cout = lsr_x[0]; end
                SH_AR: begin res = asr_x[W:1];   cout = asr_x[0]; end
                default: begin res = ror_r;      cout = ror_r[W-1]; end
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({val, kind, amt, cin})) begin
            // R5
            ror_popcount_chk: assert (kind != SH_RR || $countones(res) == $countones(val));
            // R5
            lsr_topzero_chk: assert (kind != SH_LR || amt == '0 || res[W-1] == 1'b0);
            // R6
            zero_amt_pass_chk: assert (amt != '0 || (res == val && cout == cin));
        end
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        sum  = full[W-1:0];
        cout = full[W];
        ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
    end

    always_comb begin
        if (!$isunknown({x, y, ci})) begin
            // R8
            carry_wrap_chk: assert (cout ? (sum <= x) : (sum >= x));
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TSTAND: res = a & b;
            OP_XOR, OP_TSTXOR: res = a ^ b;
            OP_OR:             res = a | b;
            OP_PASS:           res = b;
            OP_ANDN:           res = a & ~b;
            OP_NOT:            res = ~b;
            default:           res = '0;
        endcase
    end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  rn,
    input  logic [W-1:0]  rm,
    input  logic [W-1:0]  imm,
    input  logic          use_imm,
    input  logic [1:0]    shift_kind,
    input  logic [SW-1:0] shift_amt,
    input  logic [3:0]    opcode,
    input  logic          set_flags,
    input  logic [3:0]    flags_in,
    output logic [W-1:0]  result,
    output logic          rd_we,
    output logic [3:0]    flags_out
);
    alu_op_e    op;
    flags_t     fin, fout;
    arith_ctl_t ctl;
    logic [W-1:0] sh_res, op2, ax, ay_raw, ay, ar_sum, lg_res;
    logic         sh_cout, sh_c, ar_c, ar_v, ar_ci, upd, arith;

    assign op  = alu_op_e'(opcode);
    assign fin = flags_t'(flags_in);

    alu_shifter #(.W(W), .SW(SW)) u_shift (
        .val (rm),
        .kind(shift_e'(shift_kind)),
        .amt (shift_amt),
        .cin (fin.c),
        .res (sh_res),
        .cout(sh_cout)
    );

    always_comb begin
        op2    = use_imm ? imm : sh_res;
        sh_c   = use_imm ? fin.c : sh_cout;
        ctl    = arith_ctl(op);
        ax     = ctl.swap ? op2 : rn;
        ay_raw = ctl.swap ? rn : op2;
        ay     = ctl.inv ? ~ay_raw : ay_raw;
        unique case (ctl.cin)
            CI_ONE:  ar_ci = 1'b1;
            CI_FLAG: ar_ci = fin.c;
            default: ar_ci = 1'b0;
        endcase
    end

    alu_arith #(.W(W)) u_arith (
        .x   (ax),
        .y   (ay),
        .ci  (ar_ci),
        .sum (ar_sum),
        .cout(ar_c),
        .ovf (ar_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op (op),
        .a  (rn),
        .b  (op2),
        .res(lg_res)
    );

    always_comb begin
        arith  = is_arith(op);
        upd    = set_flags | is_compare(op);
        result = arith ? ar_sum : lg_res;
        rd_we  = ~is_compare(op);
        if (upd) begin
            fout.n = result[W-1];
            fout.z = (result == '0);
            fout.c = arith ? ar_c : sh_c;
            fout.v = arith ? ar_v : fin.v;
        end else begin
            fout = fin;
        end
        flags_out = fout;
    end

    always_comb begin
        if (!$isunknown({rn, rm, imm, use_imm, shift_kind, shift_amt, opcode,
                         set_flags, flags_in})) begin
            // R4
            test_nowrite_chk: assert (!(opcode[3:2] == 2'b10) || !rd_we);
            // R9
            logic_keeps_v_chk: assert (is_arith(op) || flags_out[0] == flags_in[0]);
            // R10
            no_update_hold_chk: assert (set_flags || opcode[3:2] == 2'b10 ||
                                        flags_out == flags_in);
        end
    end
endmodule

// File: tb/sim_shift_alu.sv
module sim_shift_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rn, rm, imm, result;
    logic        use_imm, set_flags, rd_we;
    logic [1:0]  shift_kind;
    logic [4:0]  shift_amt;
    logic [3:0]  opcode, flags_in, flags_out;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    shift_alu u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog expired: all requirements, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic ref_shift(input logic [31:0] v, input logic [1:0] k,
                             input logic [4:0] a, input logic ci,
                             output logic [31:0] o, output logic co);
        o  = v;
        co = ci;
        for (int i = 0; i < int'(a); i++) begin
            case (k)
                2'd0: begin co = o[31]; o = {o[30:0], 1'b0}; end
                2'd1: begin co = o[0];  o = {1'b0, o[31:1]}; end
                2'd2: begin co = o[0];  o = {o[31], o[31:1]}; end
                default: begin co = o[0]; o = {o[0], o[31:1]}; end
            endcase
        end
    endtask

    task automatic ref_model(output logic [31:0] er, output logic ewe,
                             output logic [3:0] ef);
        logic [31:0] o2;
        logic        sc, c, upd, ar;
        longint      un, uo, sn, so, u, s;
        c = flags_in[1];
        if (use_imm) begin o2 = imm; sc = c; end
        else ref_shift(rm, shift_kind, shift_amt, c, o2, sc);
        un = {32'h0, rn};
        uo = {32'h0, o2};
        sn = longint'($signed(rn));
        so = longint'($signed(o2));
        ar = 1'b1;
        u = 0; s = 0;
        case (opcode)
            4'h4, 4'hB: begin u = un + uo;         s = sn + so; end
            4'h5:       begin u = un + uo + c;     s = sn + so + c; end
            4'h2, 4'hA: begin u = un - uo;         s = sn - so; end
            4'h6:       begin u = un - uo + c - 1; s = sn - so + c - 1; end
            4'h3:       begin u = uo - un;         s = so - sn; end
            4'h7:       begin u = uo - un + c - 1; s = so - sn + c - 1; end
            default: ar = 1'b0;
        endcase
        ewe = !(opcode[3:2] == 2'b10);
        upd = set_flags || !ewe;
        if (ar) begin
            er = u[31:0];
        end else begin
            case (opcode)
                4'h0, 4'h8: er = rn & o2;
                4'h1, 4'h9: er = rn ^ o2;
                4'hC:       er = rn | o2;
                4'hD:       er = o2;
                4'hE:       er = rn & ~o2;
                default:    er = ~o2;
            endcase
        end
        if (!upd) ef = flags_in;
        else if (ar) begin
            // additions carry at 2^32; subtractions carry when no borrow
            if (opcode inside {4'h4, 4'h5, 4'hB}) ef[1] = (u >= 64'sh1_0000_0000);
            else ef[1] = (u >= 0);
            ef[0] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            ef[3] = er[31];
            ef[2] = (er == 32'h0);
        end else begin
            ef = {er[31], er == 32'h0, sc, flags_in[0]};
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] im, input logic ui,
                         input logic [1:0] k, input logic [4:0] amt,
                         input logic [3:0] op, input logic sf,
                         input logic [3:0] fi, input string tag);
        logic [31:0] er;
        logic        ewe;
        logic [3:0]  ef;
        @(negedge clk);
        rn = a; rm = b; imm = im; use_imm = ui; shift_kind = k;
        shift_amt = amt; opcode = op; set_flags = sf; flags_in = fi;
        #1;
        ref_model(er, ewe, ef);
        vectors = vectors + 1;
        if (rd_we !== ewe || (ewe && result !== er) || flags_out !== ef) begin
            miscompares = miscompares + 1;
            $display("FAIL %s op=%h: actual res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
                     tag, op, result, rd_we, flags_out, er, ewe, ef);
        end
    endtask

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'h0, 4'h1, 4'hC, 4'hD, 4'hE, 4'hF: return "R1/R9";
            4'h2, 4'h3, 4'h4: return "R2/R8";
            4'h5, 4'h6, 4'h7: return "R3/R8";
            default: return "R4";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rn = '0; rm = '0; imm = '0; use_imm = 0; shift_kind = 0; shift_amt = 0;
        opcode = 4'hD; set_flags = 0; flags_in = 4'b0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: pass of zero with update sets Z (R7)
        apply(0, 0, 0, 0, 0, 0, 4'hD, 1, 4'b0000, "R7 idle");
        // R1 logical functions
        apply(32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0, 0, 4'hE, 0, 4'b1010, "R1 and-not");
        apply(32'h0, 32'h1234_5678, 0, 0, 0, 0, 4'hF, 1, 4'b0001, "R1 not/R9 v kept");
        // R2 subtract to negative, borrow clears C (R8)
        apply(32'h0, 32'h1, 0, 0, 0, 0, 4'h2, 1, 4'b0010, "R2 sub borrow R8");
        apply(32'h5, 32'h3, 0, 0, 0, 0, 4'h3, 1, 4'b0000, "R2 rsub");
        // R8 signed overflow edge
        apply(32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 4'h4, 1, 4'b0000, "R8 add ovf");
        apply(32'h8000_0000, 32'h1, 0, 0, 0, 0, 4'h2, 1, 4'b0000, "R8 sub ovf");
        // R3 carry-using codes with C=0 and C=1
        apply(32'hFFFF_FFFF, 32'h0, 0, 0, 0, 0, 4'h5, 1, 4'b0010, "R3 addc wrap");
        apply(32'h10, 32'h10, 0, 0, 0, 0, 4'h6, 1, 4'b0000, "R3 subc c0");
        apply(32'h10, 32'h20, 0, 0, 0, 0, 4'h7, 1, 4'b0010, "R3 rsubc c1");
        // R4 compare equal: Z=1, C=1, no write, set_flags low
        apply(32'h55, 32'h55, 0, 0, 0, 0, 4'hA, 0, 4'b0000, "R4 cmp equal");
        apply(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 4'hB, 0, 4'b0000, "R4 cmpadd");
        apply(32'hF0, 32'h0F, 0, 0, 0, 0, 4'h8, 0, 4'b1111, "R4 tstand zero");
        // R5 shift kinds with carry out (R9)
        apply(0, 32'h8000_0001, 0, 0, 2'd0, 5'd1, 4'hD, 1, 4'b0000, "R5 ll carry");
        apply(0, 32'h8000_0001, 0, 0, 2'd1, 5'd1, 4'hD, 1, 4'b0000, "R5 lr carry");
        apply(0, 32'h8000_0000, 0, 0, 2'd2, 5'd31, 4'hD, 1, 4'b0000, "R5 ar sign");
        apply(0, 32'h0000_00F1, 0, 0, 2'd3, 5'd4, 4'hD, 1, 4'b0000, "R5 rr");
        // R6 zero distance and immediate keep incoming C
        apply(0, 32'h8000_0001, 0, 0, 2'd2, 5'd0, 4'hD, 1, 4'b0010, "R6 zero amt");
        apply(0, 32'h1, 32'hABCD_0000, 1, 2'd0, 5'd3, 4'hD, 1, 4'b0010, "R6 imm");
        // R10 no update request
        apply(32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 4'h4, 0, 4'b0101, "R10 hold");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b, im;
            logic [3:0]  op;
            a  = $urandom();
            b  = $urandom();
            im = $urandom();
            if ($urandom_range(0, 7) == 0) a = 32'h7FFF_FFFF + $urandom_range(0, 2);
            if ($urandom_range(0, 7) == 0) b = a;
            op = 4'($urandom_range(0, 15));
            apply(a, b, im, 1'($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)),
                  ($urandom_range(0, 5) == 0) ? 5'd0 : 5'($urandom_range(0, 31)),
                  op, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), tag_of(op));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule